// File: doc/BRIEF.md
# Addend-Driven Fractional Time Counter

This block keeps a 64-bit system time value that advances at a programmable nominal rate. The rate comes from a clock that runs faster than the wanted tick rate. On every edge of that clock, a 32-bit phase accumulator adds a software-written addend, modulo 2^32. Each carry out of that addition advances the time value by exactly one tick. Software chooses the addend as 2^32 divided by the ratio of clock frequency to tick frequency, and that ratio must be greater than 1. The 32-bit accumulator therefore sets the rate resolution to one part in 2^32 of the clock frequency. A servo can trim the rate by rewriting the addend. The fraction left in the accumulator is never cleared, so a rewrite causes no phase jump.

Software loads the time as two 32-bit words. The low word is held in a staging register. A write of the high word then updates the whole 64-bit value in one cycle. When software reads the low word, the block copies the high word into a holding register, so a high-word read that follows belongs to the same instant. Capture logic outside the block can sample the full 64-bit value directly.

Top module: `frac_time_counter`

## Requirements
- R1: After reset, the time value, the addend and the accumulator are all zero, and the time value does not change until a non-zero addend is written.
- R2: On each clock edge, the accumulator adds the addend modulo 2^32. The time value increases by exactly one on an edge where that addition carries out of bit 31, and it holds on any other edge. Example: with addend 0x80000000 and the accumulator at zero, the time value advances on every second edge.
- R3: An addend written on edge k is first used in the addition on edge k+1. The fraction already held in the accumulator is kept.
- R4: A low-word time write only fills the staging register. The time value keeps counting as before until a high-word write happens.
- R5: A high-word write sets the time value to {written high word, staged low word} on that edge. If a carry happens on the same edge, the load wins and that tick is dropped.
- R6: A low-read strobe on an edge copies the high 32 bits of the time value as they were before that edge into the held high word. The held high word does not change until the next strobe, so it pairs with the low word presented before that edge.
- R7: With the addend 0x9B26C9B3 (clock-to-tick ratio 1.65, for example 66 MHz to 40 MHz), exactly 400 ticks occur in 660 edges after reset. With 0xE8BA2E8C (ratio 1.1), exactly 100 ticks occur in 110 edges.
- R8: The time value wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_we | input | 1 | Write strobe for the addend |
| addend_wdata | input | 32 | New addend value |
| time_lo_we | input | 1 | Write strobe for the staged low time word |
| time_hi_we | input | 1 | Write strobe for the high time word; loads all 64 bits |
| time_wdata | input | 32 | Data for time word writes |
| time_lo_rd | input | 1 | Low-word read strobe; copies the high word into the holding register |
| time_lo_rdata | output | 32 | Current low 32 bits of the time value |
| time_hi_rdata | output | 32 | High word held by the last low-word read |
| sys_time | output | 64 | Current time value, for capture logic |

## Verification
A high-word load and an accumulator carry can fall on the same edge. The bench sets the addend to 0x80000000 so that carries come on every second edge. It then issues a high-word write on the exact edge of a carry. The load must win with no tick added, and the next carry, two edges later, must add exactly one. A second collision pairs a low-read strobe with a carry that ripples into the high word. The held high word must show the value from before the carry.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  parameter int unsigned FTC_ACC_W  = 32;
  parameter int unsigned FTC_WORD_W = 32;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_TICK = 2'd1,
    UPD_LOAD = 2'd2
  } time_upd_e;
endpackage

// File: rtl/ftc_phase_acc.sv
module ftc_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_we,
  input  logic [ACC_W-1:0] addend_wdata,
  output logic             tick_o
);
  logic [ACC_W-1:0] addend_q, addend_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, addend_q};
    acc_d    = sum[ACC_W-1:0];
    tick_o   = sum[ACC_W];
    addend_d = addend_we ? addend_wdata : addend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_q <= '0;
      acc_q    <= '0;
    end else begin
      addend_q <= addend_d;
      acc_q    <= acc_d;
    end
  end

  // R1: a zero addend leaves the accumulator unchanged
  a_r1_idle_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_q == '0) |=> (acc_q == $past(acc_q)));

  // R3: a written addend is the one in use after the edge
  a_r3_addend_take: assert property (@(posedge clk) disable iff (!rst_n)
    addend_we |=> (addend_q == $past(addend_wdata)));
endmodule

// File: rtl/ftc_time_reg.sv
module ftc_time_reg
  import ftc_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [WORD_W-1:0]   wdata,
  output logic [2*WORD_W-1:0] time_o
);
  localparam int unsigned TIME_W = 2 * WORD_W;

  logic [WORD_W-1:0] stage_q, stage_d;
  logic [TIME_W-1:0] time_q, time_d;
  time_upd_e         upd;

  always_comb begin
    if (hi_we)       upd = UPD_LOAD;
    else if (tick_i) upd = UPD_TICK;
    else             upd = UPD_HOLD;

    unique case (upd)
      UPD_LOAD: time_d = {wdata, stage_q};
      UPD_TICK: time_d = time_q + TIME_W'(1);
      default:  time_d = time_q;
    endcase

    stage_d = lo_we ? wdata : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      time_q  <= '0;
    end else begin
      stage_q <= stage_d;
      time_q  <= time_d;
    end
  end

  assign time_o = time_q;

  // R2: without a load, the time value moves by the carry only
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> (time_q == $past(time_q) + TIME_W'($past(tick_i))));

  // R5: a high-word write loads both words, dropping any same-edge tick
  a_r5_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> (time_q == {$past(wdata), $past(stage_q)}));
endmodule

// File: rtl/ftc_read_latch.sv
module ftc_read_latch #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [WORD_W-1:0] hi_i,
  output logic [WORD_W-1:0] hi_o
);
  logic [WORD_W-1:0] hold_q, hold_d;

  always_comb hold_d = rd_stb ? hi_i : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hi_o = hold_q;

  // R6: the held high word only changes on a read strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(hold_q));
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
  import ftc_pkg::*;
#(
  parameter int unsigned ACC_W  = FTC_ACC_W,
  parameter int unsigned WORD_W = FTC_WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addend_we,
  input  logic [ACC_W-1:0]    addend_wdata,
  input  logic                time_lo_we,
  input  logic                time_hi_we,
  input  logic [WORD_W-1:0]   time_wdata,
  input  logic                time_lo_rd,
  output logic [WORD_W-1:0]   time_lo_rdata,
  output logic [WORD_W-1:0]   time_hi_rdata,
  output logic [2*WORD_W-1:0] sys_time
);
  localparam int unsigned TIME_W = 2 * WORD_W;

  logic tick;

  ftc_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .addend_we    (addend_we),
    .addend_wdata (addend_wdata),
    .tick_o       (tick)
  );

  ftc_time_reg #(.WORD_W(WORD_W)) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .lo_we  (time_lo_we),
    .hi_we  (time_hi_we),
    .wdata  (time_wdata),
    .time_o (sys_time)
  );

  ftc_read_latch #(.WORD_W(WORD_W)) u_rdl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (time_lo_rd),
    .hi_i   (sys_time[TIME_W-1:WORD_W]),
    .hi_o   (time_hi_rdata)
  );

  assign time_lo_rdata = sys_time[WORD_W-1:0];

  // R4: without a high-word write the time value advances by at most one
  a_r4_no_partial_load: assert property (@(posedge clk) disable iff (!rst_n)
    !time_hi_we |=> ((sys_time - $past(sys_time)) <= TIME_W'(1)));
endmodule

// File: tb/frac_time_counter_tb.sv
module frac_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addend_we, time_lo_we, time_hi_we, time_lo_rd;
  logic [31:0] addend_wdata, time_wdata;
  logic [31:0] time_lo_rdata, time_hi_rdata;
  logic [63:0] sys_time;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  frac_time_counter u_dut (
    .clk(clk), .rst_n(rst_n),
    .addend_we(addend_we), .addend_wdata(addend_wdata),
    .time_lo_we(time_lo_we), .time_hi_we(time_hi_we), .time_wdata(time_wdata),
    .time_lo_rd(time_lo_rd), .time_lo_rdata(time_lo_rdata),
    .time_hi_rdata(time_hi_rdata), .sys_time(sys_time)
  );

  // reference model built from the requirements
  logic [31:0] m_add, m_acc, m_stage, m_hold;
  logic [63:0] m_time;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_add <= '0; m_acc <= '0; m_stage <= '0; m_hold <= '0; m_time <= '0;
    end else begin
      logic [32:0] s;
      s = {1'b0, m_acc} + {1'b0, m_add};
      m_acc <= s[31:0];
      if (time_hi_we)  m_time <= {time_wdata, m_stage};
      else if (s[32])  m_time <= m_time + 64'd1;
      if (time_lo_we)  m_stage <= time_wdata;
      if (addend_we)   m_add <= addend_wdata;
      if (time_lo_rd)  m_hold <= m_time[63:32];
    end
  end

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    addend_we = 0; time_lo_we = 0; time_hi_we = 0; time_lo_rd = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    addend_we = 0; time_lo_we = 0; time_hi_we = 0; time_lo_rd = 0;
    addend_wdata = '0; time_wdata = '0;
    rst_n = 0;
    steps(2);
    rst_n = 1;
    steps(1);
  endtask

  task automatic wr_addend(input logic [31:0] v);
    addend_we = 1; addend_wdata = v; step();
  endtask

  task automatic load_time(input logic [63:0] v);
    time_lo_we = 1; time_wdata = v[31:0]; step();
    time_hi_we = 1; time_wdata = v[63:32]; step();
  endtask

  task automatic t_reset();
    do_reset();
    check64("R1 reset time", sys_time, 64'd0);
    steps(20);
    check64("R1 no advance with zero addend", sys_time, 64'd0);
    check64("R1 held hi zero", {32'd0, time_hi_rdata}, 64'd0);
  endtask

  task automatic t_half_rate();
    do_reset();
    wr_addend(32'h8000_0000);          // edge A
    step();                            // A+1: acc = 0x8000_0000
    check64("R2 no carry yet", sys_time, 64'd0);
    step();                            // A+2: carry
    check64("R2 first carry", sys_time, 64'd1);
    steps(10);
    check64("R2 half rate", sys_time, 64'd6);
    check64("R2 model", sys_time, m_time);
  endtask

  task automatic t_residual();
    do_reset();
    wr_addend(32'h4000_0000);          // A
    steps(3);                          // acc = 0xC000_0000, no carry
    check64("R3 before change", sys_time, 64'd0);
    wr_addend(32'h8000_0000);          // edge adds old 0x4000_0000 -> carry, acc=0
    check64("R3 old addend until edge after write", sys_time, 64'd1);
    step();                            // acc = 0x8000_0000
    check64("R3 residual kept", sys_time, 64'd1);
    step();
    check64("R3 new addend in effect", sys_time, 64'd2);
  endtask

  task automatic t_staged_low();
    do_reset();
    wr_addend(32'h8000_0000);
    time_lo_we = 1; time_wdata = 32'hDEAD_BEEF; step();   // A+1
    steps(3);                                              // A+4
    check64("R4 low write alone has no effect", sys_time, 64'd2);
    time_hi_we = 1; time_wdata = 32'h0000_0012; step();    // A+5 (no carry)
    check64("R5 atomic load", sys_time, 64'h0000_0012_DEAD_BEEF);
  endtask

  task automatic t_load_collision();
    do_reset();
    time_lo_we = 1; time_wdata = 32'h0000_0100; step();
    wr_addend(32'h8000_0000);          // A
    step();                            // A+1
    time_hi_we = 1; time_wdata = 32'h0000_0007; step();   // A+2 carry + load
    check64("R5 load wins over carry", sys_time, 64'h0000_0007_0000_0100);
    steps(2);                          // A+4 carry
    check64("R5 next carry counts", sys_time, 64'h0000_0007_0000_0101);
  endtask

  task automatic t_read_coherent();
    logic [31:0] lo_seen;
    do_reset();
    load_time(64'h0000_0001_FFFF_FFFF);   // addend zero, no ticks
    wr_addend(32'h8000_0000);          // A
    step();                            // A+1
    lo_seen = time_lo_rdata;
    time_lo_rd = 1; step();            // A+2 carry into high word
    check64("R6 low seen before edge", {32'd0, lo_seen}, 64'h0000_0000_FFFF_FFFF);
    check64("R6 held hi is pre-carry", {32'd0, time_hi_rdata}, 64'd1);
    check64("R6 time carried", sys_time, 64'h0000_0002_0000_0000);
    steps(4);
    check64("R6 held hi stable without strobe", {32'd0, time_hi_rdata}, 64'd1);
    time_lo_rd = 1; step();
    check64("R6 held hi updated", {32'd0, time_hi_rdata}, {32'd0, m_hold});
  endtask

  task automatic t_rates();
    do_reset();
    wr_addend(32'h9B26_C9B3);
    steps(660);
    check64("R7 ratio 1.65 gives 400 ticks", sys_time, 64'd400);
    do_reset();
    wr_addend(32'hE8BA_2E8C);
    steps(110);
    check64("R7 ratio 1.1 gives 100 ticks", sys_time, 64'd100);
  endtask

  task automatic t_wrap();
    do_reset();
    load_time(64'hFFFF_FFFF_FFFF_FFFF);
    check64("R8 loaded all ones", sys_time, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_addend(32'h8000_0000);
    steps(2);
    check64("R8 wrap to zero", sys_time, 64'd0);
    check64("R2 model after wrap", sys_time, m_time);
  endtask

  initial begin
    t_reset();
    t_half_rate();
    t_residual();
    t_staged_low();
    t_load_collision();
    t_read_coherent();
    t_rates();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule